// File: doc/BRIEF.md
# Serial port register and interrupt front end

This block sits between a 32-bit register bus and the bit-level transmit and receive engines of a serial port. Software sees four word registers: control, receive data, transmit data and status. The block holds a transmit FIFO and a receive FIFO. It keeps sticky event flags that software clears by writing ones. It drives one level-high interrupt line. The serial engines attach through two byte streams that use valid/ready handshakes.

Transmit stream rules: `tx_valid` is high while the port is enabled, the TX FIFO holds data, and flow control does not hold it back. A byte leaves the FIFO on each cycle where `tx_valid` and `tx_ready` are both high.

Receive stream rules: `rx_ready` is high while the port is enabled and the RX FIFO has room. A byte is taken on each cycle where `rx_valid` and `rx_ready` are both high. The receive engine cannot stall a line, so if it offers a byte while the port is enabled and the FIFO is full, the byte is discarded and the overrun flag is set.

The bus is a single-cycle strobe. A write takes effect on the clock edge where it is sampled. A read returns data combinationally in the same cycle, and a read of the receive data register pops one entry at that edge.

Top module: `sio_regif`

## Requirements
- R1: After reset, the control register reads 0. The status register reads 0x522: TX pending (bit 1), RX FIFO empty (bit 5), RTS state (bit 8) and TX FIFO empty (bit 10) are set, and all other bits are 0. `irq` is 0.
- R2: The control register (offset 0x0) stores only the following bits, and all other bits read back 0:
  - bit 12: flow control
  - bit 14: level select
  - bit 15: port enable
  - bits 16 and 17: RX and TX DMA enables, stored only
  - bits 18 and 19: RX and TX interrupt enables
  - bit 20: loopback
- R3: A write to offset 0x8 pushes bits 7:0 into the TX FIFO. Bytes leave on the TX stream in write order, and only while control bit 15 is 1.
- R4: A write to offset 0x8 while the TX FIFO is full is dropped and sets status bit 3. Status bit 6 is 1 exactly when the TX FIFO is full.
- R5: A read of offset 0x4 returns the oldest received byte in bits 7:0 and pops it. A read with the RX FIFO empty returns 0 and pops nothing. Status bit 5 shows RX FIFO empty.
- R6: A receive byte offered while the port is enabled and the RX FIFO is full is discarded, and status bit 4... is not touched; instead status bit 2 (overrun) is set. A byte offered while the port is disabled is ignored and sets no flag.
- R7: A byte accepted with `rx_err` high sets status bit 4.
- R8: Writing 1 to any of status bits 0 to 4 clears that bit, unless its set condition holds in the same cycle. Writing 0 leaves the bit unchanged.
- R9: Status bit 0 (RX pending) becomes 1 one cycle after the RX FIFO is non-empty. Status bit 1 (TX pending) becomes 1 one cycle after the TX FIFO is empty.
- R10: `irq` equals (bit 0 AND control bit 18) OR (bit 1 AND control bit 19).
- R11: Status bits 16:11 hold the TX FIFO count when control bit 14 is 1, and the RX FIFO count when it is 0.
- R12: With control bit 12 set, `tx_valid` stays 0 while `cts_in` is 0, and `rts_out` is the inverse of RX FIFO full. With bit 12 clear, `rts_out` is 1. Status bit 7 shows `cts_in` and status bit 8 shows `rts_out`.
- R13: `loop_en` follows control bit 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| tx_valid | output | 1 | TX stream byte available |
| tx_ready | input | 1 | TX engine takes the byte |
| tx_data | output | 8 | TX stream byte |
| rx_valid | input | 1 | RX engine offers a byte |
| rx_ready | output | 1 | RX FIFO accepts a byte |
| rx_data | input | 8 | RX stream byte |
| rx_err | input | 1 | Character error for the offered byte |
| cts_in | input | 1 | Clear-to-send line state |
| rts_out | output | 1 | Request-to-send line state |
| loop_en | output | 1 | Loopback request to the serial engine |
| irq | output | 1 | Level-high interrupt |

## Verification
The bench builds the block with its default depths of 16 for both FIFOs. At that size, filling either FIFO to the brim takes only a few dozen bus cycles. This puts the dropped seventeenth TX write, the RX overrun and the release of RTS at full within easy reach, together with the widest level value of 16 in the shared field. A 32-entry TX build would only lengthen the fill loops.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 4;
  localparam int BYTE_W = 8;
  localparam int LVL_W  = 6;
  localparam int NFLAG  = 5;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_RXD  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_TXD  = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_STAT = 4'hC;

  // control bit positions
  localparam int C_FLOW  = 12;
  localparam int C_LSEL  = 14;
  localparam int C_EN    = 15;
  localparam int C_RXDMA = 16;
  localparam int C_TXDMA = 17;
  localparam int C_RXIE  = 18;
  localparam int C_TXIE  = 19;
  localparam int C_LOOP  = 20;

  localparam logic [BUS_W-1:0] CTRL_MASK =
    (32'd1 << C_FLOW) | (32'd1 << C_LSEL) | (32'd1 << C_EN) |
    (32'd1 << C_RXDMA) | (32'd1 << C_TXDMA) | (32'd1 << C_RXIE) |
    (32'd1 << C_TXIE) | (32'd1 << C_LOOP);

  // status bit positions; flags occupy 0..NFLAG-1
  localparam int S_RXP   = 0;
  localparam int S_TXP   = 1;
  localparam int S_OVR   = 2;
  localparam int S_TXERR = 3;
  localparam int S_CHERR = 4;
  localparam int S_RXE   = 5;
  localparam int S_TXF   = 6;
  localparam int S_CTS   = 7;
  localparam int S_RTS   = 8;
  localparam int S_TXE   = 10;
  localparam int S_LVL   = 11;
endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign rdata = mem[rd_ptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full));
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && empty));
endmodule

// File: rtl/sio_flags.sv
module sio_flags
  import sio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_nonempty,
  input  logic             tx_empty,
  input  logic             set_ovr,
  input  logic             set_txerr,
  input  logic             set_cherr,
  input  logic [NFLAG-1:0] clr,
  input  logic             rx_ie,
  input  logic             tx_ie,
  output logic [NFLAG-1:0] flags,
  output logic             irq
);
  logic [NFLAG-1:0] set_v;

  always_comb begin
    set_v          = '0;
    set_v[S_RXP]   = rx_nonempty;
    set_v[S_TXP]   = tx_empty;
    set_v[S_OVR]   = set_ovr;
    set_v[S_TXERR] = set_txerr;
    set_v[S_CHERR] = set_cherr;
  end

  // set wins over a same-cycle write-one-to-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= set_v | (flags & ~clr);
  end

  assign irq = (flags[S_RXP] & rx_ie) | (flags[S_TXP] & tx_ie);

  assert_rxpend_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_nonempty |=> flags[S_RXP]);
  assert_w1c_ovr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[S_OVR] && !set_ovr) |=> !flags[S_OVR]);
endmodule

// File: rtl/sio_regif.sv
module sio_regif
  import sio_pkg::*;
#(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_err,
  input  logic              cts_in,
  output logic              rts_out,
  output logic              loop_en,
  output logic              irq
);
  localparam int TX_CW = $clog2(TX_DEPTH + 1);
  localparam int RX_CW = $clog2(RX_DEPTH + 1);

  logic [BUS_W-1:0]  ctrl_q;
  logic              wr_ctrl, wr_txd, wr_stat, rd_rxd;
  logic              port_en, flow_on;
  logic              tx_push, tx_pop, tx_full, tx_empty, tx_drop;
  logic              rx_push, rx_pop, rx_full, rx_empty, rx_ovr;
  logic [TX_CW-1:0]  tx_cnt;
  logic [RX_CW-1:0]  rx_cnt;
  logic [BYTE_W-1:0] rx_head;
  logic [NFLAG-1:0]  flags, clr;
  logic [LVL_W-1:0]  level;
  logic [BUS_W-1:0]  stat;

  assign wr_ctrl = bus_sel &&  bus_wr && (bus_addr == OFS_CTRL);
  assign wr_txd  = bus_sel &&  bus_wr && (bus_addr == OFS_TXD);
  assign wr_stat = bus_sel &&  bus_wr && (bus_addr == OFS_STAT);
  assign rd_rxd  = bus_sel && !bus_wr && (bus_addr == OFS_RXD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_MASK;
  end

  assign port_en = ctrl_q[C_EN];
  assign flow_on = ctrl_q[C_FLOW];
  assign loop_en = ctrl_q[C_LOOP];

  // transmit side
  assign tx_push  = wr_txd && !tx_full;
  assign tx_drop  = wr_txd &&  tx_full;
  assign tx_valid = port_en && !tx_empty && (!flow_on || cts_in);
  assign tx_pop   = tx_valid && tx_ready;

  sio_fifo #(.W(BYTE_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .wdata(bus_wdata[BYTE_W-1:0]),
    .pop(tx_pop), .rdata(tx_data),
    .full(tx_full), .empty(tx_empty), .count(tx_cnt)
  );

  // receive side
  assign rx_ready = port_en && !rx_full;
  assign rx_push  = rx_valid && rx_ready;
  assign rx_ovr   = rx_valid && port_en && rx_full;
  assign rx_pop   = rd_rxd && !rx_empty;
  assign rts_out  = !flow_on || !rx_full;

  sio_fifo #(.W(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .wdata(rx_data),
    .pop(rx_pop), .rdata(rx_head),
    .full(rx_full), .empty(rx_empty), .count(rx_cnt)
  );

  // sticky flags and interrupt
  assign clr = wr_stat ? bus_wdata[NFLAG-1:0] : '0;

  sio_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .rx_nonempty(!rx_empty), .tx_empty(tx_empty),
    .set_ovr(rx_ovr), .set_txerr(tx_drop), .set_cherr(rx_push && rx_err),
    .clr(clr), .rx_ie(ctrl_q[C_RXIE]), .tx_ie(ctrl_q[C_TXIE]),
    .flags(flags), .irq(irq)
  );

  // status word and read mux
  assign level = ctrl_q[C_LSEL] ? LVL_W'(tx_cnt) : LVL_W'(rx_cnt);

  always_comb begin
    stat                 = '0;
    stat[NFLAG-1:0]      = flags;
    stat[S_RXE]          = rx_empty;
    stat[S_TXF]          = tx_full;
    stat[S_CTS]          = cts_in;
    stat[S_RTS]          = rts_out;
    stat[S_TXE]          = tx_empty;
    stat[S_LVL +: LVL_W] = level;
  end

  always_comb begin
    unique case (bus_addr)
      OFS_CTRL: bus_rdata = ctrl_q;
      OFS_RXD:  bus_rdata = rx_empty ? '0 : BUS_W'(rx_head);
      OFS_STAT: bus_rdata = stat;
      default:  bus_rdata = '0;
    endcase
  end

  assert_cts_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_on && !cts_in) |-> !tx_valid);
  assert_txdrop_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_txd && tx_full) |=> stat[S_TXERR]);
  assert_overrun_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && port_en && rx_full) |=> stat[S_OVR]);
  assert_rx_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxd && rx_empty) |-> (bus_rdata == '0));
endmodule

// File: tb/sio_regif_tb.sv
module sio_regif_tb;
  import sio_pkg::*;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        tx_valid, tx_ready = 0, rx_ready, rts_out, loop_en, irq;
  logic [7:0]  tx_data, rx_data = '0;
  logic        rx_valid = 0, rx_err = 0, cts_in = 0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] txq[$];

  always #(CLK_P/2) clk = ~clk;

  sio_regif u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_err(rx_err), .cts_in(cts_in), .rts_out(rts_out),
    .loop_en(loop_en), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  // driver: records expected TX bytes before writing them
  task automatic tx_write(logic [7:0] b, bit accepted);
    if (accepted) txq.push_back(b);
    bus_write(OFS_TXD, {24'd0, b});
  endtask

  task automatic rx_send(logic [7:0] b, logic e);
    @(negedge clk);
    rx_valid = 1; rx_data = b; rx_err = e;
    @(negedge clk);
    rx_valid = 0; rx_err = 0;
  endtask

  // monitor: a handshake seen here completes at the next rising edge
  always @(negedge clk) begin
    #2;
    if (rst_n && tx_valid && tx_ready) begin
      if (txq.size() == 0) chk("R3 unexpected tx byte", {24'd0, tx_data}, 32'hxx);
      else chk("R3 tx stream order", {24'd0, tx_data}, {24'd0, txq.pop_front()});
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    bus_read(OFS_CTRL, d); chk("R1 ctrl reset", d, 32'h0);
    bus_read(OFS_STAT, d); chk("R1 status reset", d, 32'h522);
    chk("R1 irq reset", irq, 0);

    // R2 stored bits, R13 loopback, R10 tx interrupt
    bus_write(OFS_CTRL, 32'hFFFF_FFFF);
    bus_read(OFS_CTRL, d); chk("R2 ctrl mask", d, 32'h001F_D000);
    chk("R13 loop_en on", loop_en, 1);
    chk("R10 irq from tx pending", irq, 1);
    bus_write(OFS_CTRL, 32'h0);
    chk("R13 loop_en off", loop_en, 0);

    // R3 disabled hold, R11 tx level, R8 w1c of tx pending
    tx_ready = 1;
    bus_write(OFS_CTRL, 32'h4000);
    tx_write(8'hA1, 1); tx_write(8'hB2, 1); tx_write(8'hC3, 1);
    repeat (4) @(negedge clk);
    chk("R3 no tx while disabled", tx_valid, 0);
    bus_read(OFS_STAT, d); chk("R11 tx level 3", (d >> 11) & 32'h3F, 3);
    chk("R8 tx pending before clear", d[1], 1);
    bus_write(OFS_STAT, 32'h2);
    bus_read(OFS_STAT, d); chk("R8 tx pending cleared", d[1], 0);
    bus_write(OFS_CTRL, 32'hC000);
    while (txq.size() != 0) @(negedge clk);
    bus_read(OFS_STAT, d);
    chk("R11 tx level drained", (d >> 11) & 32'h3F, 0);
    chk("R9 tx pending after empty", d[1], 1);

    // R4 full and drop
    bus_write(OFS_CTRL, 32'h4000);
    for (int i = 0; i < 16; i++) tx_write(8'h40 + 8'(i), 1);
    bus_read(OFS_STAT, d);
    chk("R4 tx full flag", d[6], 1); chk("R4 no error yet", d[3], 0);
    chk("R11 tx level 16", (d >> 11) & 32'h3F, 16);
    tx_write(8'hEE, 0);
    bus_read(OFS_STAT, d); chk("R4 drop sets error", d[3], 1);
    bus_write(OFS_STAT, 32'h0);
    bus_read(OFS_STAT, d); chk("R8 write zero keeps flag", d[3], 1);
    bus_write(OFS_STAT, 32'h8);
    bus_read(OFS_STAT, d); chk("R8 error cleared", d[3], 0);
    bus_write(OFS_CTRL, 32'hC000);
    while (txq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R4 dropped byte never sent", tx_valid, 0);

    // R12 flow control
    bus_write(OFS_CTRL, 32'hD000);
    tx_write(8'h5A, 1);
    repeat (5) @(negedge clk);
    chk("R12 cts low holds tx", tx_valid, 0);
    bus_read(OFS_STAT, d);
    chk("R12 cts state shown", d[7], 0); chk("R12 rts high not full", d[8], 1);
    cts_in = 1;
    while (txq.size() != 0) @(negedge clk);
    bus_read(OFS_STAT, d); chk("R12 cts high shown", d[7], 1);

    // R5 R7 R9 R10 receive path
    bus_write(OFS_CTRL, 32'h4_8000);
    chk("R10 irq off with rx empty", irq, 0);
    rx_send(8'h11, 0); rx_send(8'h22, 1);
    bus_read(OFS_STAT, d);
    chk("R11 rx level 2", (d >> 11) & 32'h3F, 2);
    chk("R7 char error flag", d[4], 1);
    chk("R9 rx pending", d[0], 1);
    chk("R10 irq from rx", irq, 1);
    bus_read(OFS_RXD, d); chk("R5 first byte", d, 32'h11);
    bus_read(OFS_RXD, d); chk("R5 second byte", d, 32'h22);
    bus_read(OFS_RXD, d); chk("R5 empty read zero", d, 32'h0);
    bus_write(OFS_STAT, 32'h1F);
    bus_read(OFS_STAT, d);
    chk("R8 rx flags cleared", d[4:0], 32'h2);
    chk("R5 rx empty flag", d[5], 1);
    chk("R10 irq drops after clear", irq, 0);

    // R6 overrun and RTS at full
    bus_write(OFS_CTRL, 32'h9000);
    for (int i = 0; i < 16; i++) rx_send(8'h80 + 8'(i), 0);
    chk("R6 rx_ready low when full", rx_ready, 0);
    bus_read(OFS_STAT, d);
    chk("R12 rts low at full", d[8], 0); chk("R6 no overrun yet", d[2], 0);
    rx_send(8'hEE, 0);
    bus_read(OFS_STAT, d); chk("R6 overrun flag", d[2], 1);
    for (int i = 0; i < 16; i++) begin
      bus_read(OFS_RXD, d); chk("R6 kept byte order", d, 32'h80 + i);
    end
    bus_read(OFS_STAT, d); chk("R6 discarded byte absent", d[5], 1);
    bus_write(OFS_STAT, 32'h4);

    // R6 ignored while disabled
    bus_write(OFS_CTRL, 32'h0);
    rx_send(8'h77, 1);
    bus_read(OFS_STAT, d);
    chk("R6 disabled rx ignored", d[5], 1);
    chk("R6 disabled no flags", d[4:2], 0);

    chk("R3 all tx bytes seen", txq.size(), 0);
    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule